// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked system read and write an asynchronous static RAM of 262,144 words by 16 bits. The host side uses a simple request/acknowledge handshake. The host raises `hostReq` together with the direction flag, the word address, the write data and a per-byte lane mask. It keeps the request high until it sees a single-cycle `hostAck`. For a read, the returned word is valid in the same cycle as the acknowledge.

On the memory side the controller drives the address, a pair of chip selects of opposite polarity, one active-low control per byte lane, an active-low write strobe and an active-low output enable. It also drives a split data bus: an output word, an input word and a drive-enable for the pad logic. All memory timing minimums are given in nanoseconds as parameters. The controller turns each of them into a clock count with `CLK_PERIOD_NS`: the count is the ceiling of the nanosecond value divided by the period, and never less than one.

Every access goes through the same sequence of states: idle, a single setup cycle that presents the address (and, for writes, the data), an access window, and a single hold cycle that releases all controls. When a write follows a read, an extra turnaround phase sits before the setup cycle. This gives the memory time to release the data bus before the controller drives it.

Top module: `asram_ctrl`

## Requirements
- R1: Out of reset and whenever idle, the memory side is inactive: `memCs1N`=1, `memCs2`=0, all `memBcN`=1, `memWeN`=1, `memOeN`=1, `memDqOe`=0 and `hostAck`=0.
- R2: A byte-lane control is low only while both selects are active (`memCs1N`=0 and `memCs2`=1).
- R3: In a write, `memWeN` falls in the same cycle as the selects and stays low for exactly WR_CYC cycles. WR_CYC is the largest of the counts for 55 ns strobe width, 60 ns select-to-end, 35 ns data-to-end and 70 ns cycle time. During that window `memDqOe`=1 and `memDqOut` is stable, and `memOeN` stays high.
- R4: Byte mask bit 0 enables data bits 7:0 through `memBcN[0]`, and bit 1 enables bits 15:8 through `memBcN[1]`. A masked-off lane keeps its byte control high, so its stored byte does not change.
- R5: In a read, `memOeN` is low with the selects for exactly RD_CYC cycles, the larger of the 70 ns and 35 ns counts. The bus is captured at the last clock of that window. Lanes whose mask bit is 0 return 0 in `hostRdata`.
- R6: `memAddr` is constant for the whole access window. Address, data, mask and direction are taken from the host only in idle, so host-side changes during an access have no effect.
- R7: `hostAck` is high for exactly one cycle per request. It comes in the cycle after the access window, when all memory controls are already inactive, and `hostRdata` is valid in that cycle.
- R8: When a write follows a read, `memDqOe` rises no earlier than TA_CYC cycles after `memOeN` rose, where TA_CYC is the count for 25 ns.
- R9: `memDqOe` is never 1 while `memOeN` is 0, and `memWeN` and `memOeN` are never low together.
- R10: Each count is ceil(ns / CLK_PERIOD_NS) with a minimum of one. With a 5 ns period this gives WR_CYC=14, RD_CYC=14 and TA_CYC=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReq | input | 1 | Request, held high until acknowledged |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | ADDR_W | Word address |
| hostWdata | input | DATA_W | Write data |
| hostMask | input | DATA_W/8 | Byte lane enables, bit i for bits 8i+7:8i |
| hostAck | output | 1 | One-cycle completion pulse |
| hostRdata | output | DATA_W | Read data, valid with hostAck |
| memAddr | output | ADDR_W | Memory address |
| memCs1N | output | 1 | Chip select, active low |
| memCs2 | output | 1 | Chip select, active high |
| memBcN | output | DATA_W/8 | Byte lane controls, active low |
| memWeN | output | 1 | Write strobe, active low |
| memOeN | output | 1 | Output enable, active low |
| memDqOut | output | DATA_W | Data driven to memory |
| memDqIn | input | DATA_W | Data returned from memory |
| memDqOe | output | 1 | Drive enable for memDqOut |

## Verification
The bench's memory model returns junk until output enable has been low for the full 70 ns count. A controller that samples even one cycle early therefore reads back wrong words in the full-address sweep. Partial-mask writes and reads catch a swapped or ignored lane mapping, which would corrupt the neighbouring byte or leak junk into a masked lane. Read-then-write pairs catch a missing turnaround phase, because the drive enable would rise only a few cycles after output enable was released. Changing the host inputs in the middle of an access catches a controller that passes them through live instead of latching them.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_SETUP,
    ST_ACCESS,
    ST_HOLD
  } ctlState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // take host request into the holding registers
    logic selOn;    // both chip selects and enabled lanes active
    logic weOn;     // write strobe active
    logic oeOn;     // output enable active
    logic driveOn;  // drive the write data bus
    logic capture;  // sample the read bus
  } memStrobe_t;

  function automatic int unsigned nsToCycles(input int unsigned ns,
                                             input int unsigned periodNs);
    int unsigned c;
    c = (ns + periodNs - 1) / periodNs;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned maxOf2(input int unsigned a,
                                         input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_control.sv
module asram_control
  import asram_pkg::*;
#(
  parameter int unsigned WR_CYC = 14,
  parameter int unsigned RD_CYC = 14,
  parameter int unsigned TA_CYC = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostReq,
  input  logic       hostWrite,
  output memStrobe_t strobe,
  output logic       hostAck
);

  localparam int unsigned MAX_CYC = maxOf2(maxOf2(WR_CYC, RD_CYC), TA_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  ctlState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             opWrite;
  logic             lastRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      opWrite  <= 1'b0;
      lastRead <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (hostReq) begin
            opWrite <= hostWrite;
            if (hostWrite && lastRead) begin
              state <= ST_TURN;
              cnt   <= CNT_W'(TA_CYC);
            end else begin
              state <= ST_SETUP;
            end
          end
        end
        ST_TURN: begin
          if (cnt == CNT_W'(1)) state <= ST_SETUP;
          else                  cnt   <= cnt - CNT_W'(1);
        end
        ST_SETUP: begin
          cnt   <= opWrite ? CNT_W'(WR_CYC) : CNT_W'(RD_CYC);
          state <= ST_ACCESS;
        end
        ST_ACCESS: begin
          if (cnt == CNT_W'(1)) state <= ST_HOLD;
          else                  cnt   <= cnt - CNT_W'(1);
        end
        ST_HOLD: begin
          lastRead <= !opWrite;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.load    = (state == ST_IDLE) && hostReq;
    strobe.selOn   = (state == ST_ACCESS);
    strobe.weOn    = (state == ST_ACCESS) && opWrite;
    strobe.oeOn    = (state == ST_ACCESS) && !opWrite;
    strobe.driveOn = opWrite && ((state == ST_SETUP) || (state == ST_ACCESS) ||
                                 (state == ST_HOLD));
    strobe.capture = (state == ST_ACCESS) && !opWrite && (cnt == CNT_W'(1));
  end

  assign hostAck = (state == ST_HOLD);

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strobe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [LANES-1:0]  hostMask,
  output logic [DATA_W-1:0] hostRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCs1N,
  output logic              memCs2,
  output logic [LANES-1:0]  memBcN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              memDqOe
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [LANES-1:0]  laneReg;
  logic [DATA_W-1:0] rdataReg;
  logic [DATA_W-1:0] capData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      laneReg  <= '0;
    end else if (strobe.load) begin
      addrReg  <= hostAddr;
      wdataReg <= hostWdata;
      laneReg  <= hostMask;
    end
  end

  // Masked-off lanes return zero
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      capData[i*8 +: 8] = laneReg[i] ? memDqIn[i*8 +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rdataReg <= '0;
    else if (strobe.capture) rdataReg <= capData;
  end

  assign hostRdata = rdataReg;
  assign memAddr   = addrReg;
  assign memCs1N   = !strobe.selOn;
  assign memCs2    = strobe.selOn;
  assign memBcN    = ~(laneReg & {LANES{strobe.selOn}});
  assign memWeN    = !strobe.weOn;
  assign memOeN    = !strobe.oeOn;
  assign memDqOut  = wdataReg;
  assign memDqOe   = strobe.driveOn;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W        = 18,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned CLK_PERIOD_NS = 5,
  parameter int unsigned CYCLE_NS      = 70,
  parameter int unsigned WE_PULSE_NS   = 55,
  parameter int unsigned SEL_SETUP_NS  = 60,
  parameter int unsigned DATA_SETUP_NS = 35,
  parameter int unsigned OE_ACCESS_NS  = 35,
  parameter int unsigned OE_RELEASE_NS = 25,
  localparam int unsigned LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [LANES-1:0]  hostMask,
  output logic              hostAck,
  output logic [DATA_W-1:0] hostRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCs1N,
  output logic              memCs2,
  output logic [LANES-1:0]  memBcN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              memDqOe
);

  // R10: every window is a ceiling of ns / period, at least one cycle
  localparam int unsigned WR_CYC = maxOf2(
      maxOf2(nsToCycles(WE_PULSE_NS, CLK_PERIOD_NS), nsToCycles(SEL_SETUP_NS, CLK_PERIOD_NS)),
      maxOf2(nsToCycles(DATA_SETUP_NS, CLK_PERIOD_NS), nsToCycles(CYCLE_NS, CLK_PERIOD_NS)));
  localparam int unsigned RD_CYC = maxOf2(nsToCycles(CYCLE_NS, CLK_PERIOD_NS),
                                          nsToCycles(OE_ACCESS_NS, CLK_PERIOD_NS));
  localparam int unsigned TA_CYC = nsToCycles(OE_RELEASE_NS, CLK_PERIOD_NS);

  memStrobe_t strobe;

  asram_control #(
    .WR_CYC(WR_CYC),
    .RD_CYC(RD_CYC),
    .TA_CYC(TA_CYC)
  ) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .hostReq  (hostReq),
    .hostWrite(hostWrite),
    .strobe   (strobe),
    .hostAck  (hostAck)
  );

  asram_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .hostAddr (hostAddr),
    .hostWdata(hostWdata),
    .hostMask (hostMask),
    .hostRdata(hostRdata),
    .memAddr  (memAddr),
    .memCs1N  (memCs1N),
    .memCs2   (memCs2),
    .memBcN   (memBcN),
    .memWeN   (memWeN),
    .memOeN   (memOeN),
    .memDqOut (memDqOut),
    .memDqIn  (memDqIn),
    .memDqOe  (memDqOe)
  );

endmodule

// File: rtl/asram_ctrl_checker.sv
module asram_ctrl_checker #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned LANES  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCs1N,
  input logic              memCs2,
  input logic [LANES-1:0]  memBcN,
  input logic              memWeN,
  input logic              memOeN,
  input logic              memDqOe
);

  p_lane_needs_sel_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memBcN != {LANES{1'b1}}) |-> (!memCs1N && memCs2));

  p_we_with_drive_r3: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memDqOe && !memCs1N && memCs2));

  p_we_not_late_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(memCs1N) && memOeN) |-> !memWeN);

  p_addr_steady_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!memCs1N && $past(!memCs1N)) |-> $stable(memAddr));

  p_ack_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |=> !hostAck);

  p_ack_released_r7: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |-> (memCs1N && !memCs2 && memWeN && memOeN));

  p_no_drive_in_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOeN);

  p_we_oe_apart_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(!memWeN && !memOeN));

endmodule

bind asram_ctrl asram_ctrl_checker #(
  .ADDR_W(ADDR_W),
  .LANES (LANES)
) u_checker (
  .clk    (clk),
  .rstN   (rstN),
  .hostAck(hostAck),
  .memAddr(memAddr),
  .memCs1N(memCs1N),
  .memCs2 (memCs2),
  .memBcN (memBcN),
  .memWeN (memWeN),
  .memOeN (memOeN),
  .memDqOe(memDqOe)
);

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int PERIOD = 5;
  // R10 arithmetic: ceil(ns / 5)
  localparam int WR_EXP = (70 + PERIOD - 1) / PERIOD;
  localparam int RD_EXP = (70 + PERIOD - 1) / PERIOD;
  localparam int TA_EXP = (25 + PERIOD - 1) / PERIOD;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hostReq = 1'b0;
  logic          hostWrite = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [DW-1:0] hostWdata = '0;
  logic [1:0]    hostMask = '0;
  logic          hostAck;
  logic [DW-1:0] hostRdata;
  logic [AW-1:0] memAddr;
  logic          memCs1N, memCs2, memWeN, memOeN, memDqOe;
  logic [1:0]    memBcN;
  logic [DW-1:0] memDqOut;
  logic [DW-1:0] memDqIn;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(PERIOD)) uut (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostMask(hostMask),
    .hostAck(hostAck), .hostRdata(hostRdata), .memAddr(memAddr),
    .memCs1N(memCs1N), .memCs2(memCs2), .memBcN(memBcN), .memWeN(memWeN),
    .memOeN(memOeN), .memDqOut(memDqOut), .memDqIn(memDqIn), .memDqOe(memDqOe));

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Memory model: stores enabled lanes on write, returns junk until the
  // output enable has been low for the full access time.
  logic [DW-1:0] memArr [256];
  logic [DW-1:0] shadow [256];
  int rdAge = 0;
  wire readAct  = !memCs1N && memCs2 && !memOeN && memWeN;
  wire writeAct = !memCs1N && memCs2 && !memWeN;

  always @(posedge clk) begin
    rdAge <= readAct ? rdAge + 1 : 0;
    if (writeAct && memDqOe) begin
      for (int i = 0; i < 2; i++)
        if (!memBcN[i]) memArr[memAddr][i*8 +: 8] <= memDqOut[i*8 +: 8];
    end
  end

  always_comb begin
    for (int i = 0; i < 2; i++)
      memDqIn[i*8 +: 8] = (readAct && rdAge >= RD_EXP - 1 && !memBcN[i]) ?
                          memArr[memAddr][i*8 +: 8] : 8'hA5;
  end

  // Bus monitors, sampled at the falling edge
  int weLow = 0, oeLow = 0, gap = 255;
  logic prevDrive = 1'b0;
  logic [DW-1:0] wdFirst;
  logic [AW-1:0] addrFirst;
  bit selPrev = 0, addrMoved = 0, oeDuringWe = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (!memWeN) begin
        if (weLow == 0) wdFirst = memDqOut;
        if (memDqOut != wdFirst || !memDqOe) addrMoved = 1;
        if (!memOeN) oeDuringWe = 1;
        weLow++;
      end else if (weLow != 0) begin
        check(weLow == WR_EXP, "R3 R10 write strobe width", weLow, WR_EXP);
        check(!oeDuringWe, "R3 output enable high in write", oeDuringWe, 0);
        weLow = 0;
        oeDuringWe = 0;
      end
      if (!memOeN) oeLow++;
      else if (oeLow != 0) begin
        check(oeLow == RD_EXP, "R5 R10 output enable width", oeLow, RD_EXP);
        oeLow = 0;
      end
      if (!memOeN) gap = 0;
      else if (gap < 255) gap++;
      if (memDqOe && !prevDrive)
        check(gap >= TA_EXP, "R8 turnaround before drive", gap, TA_EXP);
      prevDrive = memDqOe;
      if (memDqOe && !memOeN) check(0, "R9 drive during read", 1, 0);
      if (memBcN != 2'b11)
        check(!memCs1N && memCs2, "R2 lane low outside select", {memCs1N, memCs2}, 2'b01);
      if (!memCs1N) begin
        if (!selPrev) addrFirst = memAddr;
        else if (memAddr != addrFirst) addrMoved = 1;
      end else if (selPrev) begin
        check(!addrMoved, "R6 address or data moved in window", addrMoved, 0);
        addrMoved = 0;
      end
      selPrev = !memCs1N;
    end
  end

  logic [DW-1:0] lastRd;

  // Called at a falling edge; returns at a falling edge
  task automatic doOp(input bit wr, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [1:0] m);
    int n = 0;
    hostReq = 1'b1; hostWrite = wr; hostAddr = a; hostWdata = d; hostMask = m;
    do begin
      @(negedge clk);
      n++;
      if (!memCs1N) begin
        hostAddr = ~a; hostWdata = ~d; hostMask = ~m; hostWrite = ~wr;
      end
    end while (!hostAck && n < 100);
    check(hostAck, "R7 acknowledge seen", hostAck, 1);
    lastRd = hostRdata;
    hostReq = 1'b0;
    @(negedge clk);
    check(!hostAck, "R7 acknowledge lasts one cycle", hostAck, 0);
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return {8'(a) ^ 8'h5A, 8'hFF - 8'(a)};
  endfunction

  task automatic checkIdle(input string tag);
    check(memCs1N && !memCs2 && memBcN == 2'b11 && memWeN && memOeN &&
          !memDqOe && !hostAck, tag,
          {memCs1N, memCs2, memBcN, memWeN, memOeN, memDqOe, hostAck}, 8'b10111100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkIdle("R1 controls inactive in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1 controls inactive after reset");

    // R3: full-width write of every address
    for (int a = 0; a < 256; a++) begin
      doOp(1, AW'(a), pat(a), 2'b11);
      shadow[a] = pat(a);
    end
    // R5: read every address back
    for (int a = 0; a < 256; a++) begin
      doOp(0, AW'(a), '0, 2'b11);
      check(lastRd == shadow[a], "R5 read back", lastRd, shadow[a]);
    end
    // R4: partial-mask writes, each followed by a full read (R8 on next write)
    for (int a = 0; a < 64; a++) begin
      logic [1:0] m;
      logic [DW-1:0] d;
      m = (a % 3 == 0) ? 2'b01 : (a % 3 == 1) ? 2'b10 : 2'b00;
      d = ~pat(a) ^ {8'(a), 8'(a)};
      doOp(1, AW'(a), d, m);
      if (m[0]) shadow[a][7:0]  = d[7:0];
      if (m[1]) shadow[a][15:8] = d[15:8];
      doOp(0, AW'(a), '0, 2'b11);
      check(lastRd == shadow[a], "R4 masked lane unchanged", lastRd, shadow[a]);
    end
    // R5: partial-mask reads return zero in masked lanes
    for (int a = 64; a < 96; a++) begin
      doOp(0, AW'(a), '0, 2'b01);
      check(lastRd == {8'h00, shadow[a][7:0]}, "R5 low lane read", lastRd,
            {8'h00, shadow[a][7:0]});
      doOp(0, AW'(a), '0, 2'b10);
      check(lastRd == {shadow[a][15:8], 8'h00}, "R5 high lane read", lastRd,
            {shadow[a][15:8], 8'h00});
    end
    // R8: read immediately followed by write, then verify
    for (int a = 96; a < 112; a++) begin
      doOp(0, AW'(a), '0, 2'b11);
      check(lastRd == shadow[a], "R8 read before turnaround", lastRd, shadow[a]);
      doOp(1, AW'(a), 16'(a * 257), 2'b11);
      shadow[a] = 16'(a * 257);
    end
    for (int a = 96; a < 112; a++) begin
      doOp(0, AW'(a), '0, 2'b11);
      check(lastRd == shadow[a], "R8 write after read landed", lastRd, shadow[a]);
    end
    // R1 / R7: no activity without a request
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      checkIdle("R1 R7 quiet while idle");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule